// File: doc/BRIEF.md
# Cartridge Outer-Bank Address Translator

This block sits beside an existing inner bank-switching core in a cartridge and turns processor and picture-unit addresses into memory addresses. The inner core keeps its own registers and supplies, per slot, an 8 KB program bank number and a 1 KB character bank number. This block adds an outer layer on top of those numbers. A program override register can take over program banking in 16 KB or 32 KB units. A one-bit character outer register lifts every character bank by 256.

The block also owns 8 KB of work RAM at 0x6000–0x7FFF and, when no character ROM is fitted, an 8 KB character RAM. CPU writes at 0x8000 and above are handed to the inner core unchanged. The program mode is an enumerated value decoded from the override register: `PM_INNER` (bit 7 clear), `PM_WIDE16` (bit 7 set, bit 5 clear) and `PM_WIDE32` (bits 7 and 5 set). A write to the override register is the only transition between modes, and it takes effect on the following cycle. Each read port has a registered source state: `SRC_NONE`, `SRC_LOCAL` (on-block RAM) or `SRC_ROM` (external ROM). A read request moves the port into `SRC_LOCAL` or `SRC_ROM` for exactly one cycle. Any cycle without a decoded read returns the port to `SRC_NONE`.

Top module: `cart_outer_bank_xlat`

## Requirements
- R1: For a CPU address in 0x8000–0xFFFF, the slot is address bits 14:13. `prg_rom_addr` equals {bank, address bits 12:0}, and `prg_rom_rd` follows `cpu_rd` in the same cycle.
- R2: A CPU write to 0x6000 loads all eight data bits into the override register. A CPU write to 0x6001 loads only data bit 0 into the character outer register.
- R3: With override bit 7 clear, each slot uses the inner core's bank for that slot.
- R4: With override bits 7 and 5 set, the bank is (bits 3:1) × 4 + slot.
- R5: With bit 7 set and bit 5 clear, the bank is (bits 3:0) × 2 + slot bit 0, so the same 16 KB appears in both halves of the window.
- R6: Program banks are taken modulo 2^PRG_BANKS_LOG2. Character banks are taken modulo the number of 1 KB banks, which is 8 when character RAM is fitted.
- R7: For PPU addresses 0x0000–0x1FFF, the slot is bits 12:10. `chr_rom_addr` equals {(inner bank + 256 × outer bit) mod count, address bits 9:0}.
- R8: Work RAM can be read anywhere in 0x6000–0x7FFF. Writes store into it only from 0x6002 to 0x7FFF.
- R9: With CHR_RAM=1, PPU writes store into the character RAM and can be read back. With CHR_RAM=0, PPU writes start no ROM access and have no effect.
- R10: After reset, both outer registers are 0, banking is purely from the inner core, and both read-valid outputs are low.
- R11: CPU writes at 0x8000 and above appear on `core_wr`/`core_addr`/`core_wdata` in the same cycle. They change neither the outer registers nor the work RAM.
- R12: A CPU read below 0x6000 or a PPU read at 0x2000 and above leaves the matching read-valid output low on the next cycle.
- R13: Read data and its valid flag appear on the cycle after the read request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the request |
| cpu_rvalid | output | 1 | CPU read data is driven |
| inner_prg_bank | input | 4*INNER_W | Inner core 8 KB bank for each slot, slot 0 in the low bits |
| inner_chr_bank | input | 8*INNER_W | Inner core 1 KB bank for each slot, slot 0 in the low bits |
| core_wr | output | 1 | Write strobe forwarded to the inner core |
| core_addr | output | 16 | Forwarded write address |
| core_wdata | output | 8 | Forwarded write data |
| prg_rom_rd | output | 1 | Program ROM read strobe |
| prg_rom_addr | output | PRG_BANKS_LOG2+13 | Program ROM byte address |
| prg_rom_data | input | 8 | Program ROM data, synchronous, one cycle late |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read request |
| ppu_wr | input | 1 | PPU write request |
| ppu_wdata | input | 8 | PPU write data |
| ppu_rdata | output | 8 | PPU read data, one cycle after the request |
| ppu_rvalid | output | 1 | PPU read data is driven |
| chr_rom_rd | output | 1 | Character ROM read strobe (never set when CHR_RAM=1) |
| chr_rom_addr | output | CHR_AW | Character byte address, CHR_AW is 13 with CHR_RAM=1, else CHR_BANKS_LOG2+10 |
| chr_rom_data | input | 8 | Character ROM data, synchronous, one cycle late |

## Verification
The hardest case to reach from the ports is the unwritable pair at 0x6000–0x6001. A write there lands in a register, so the RAM byte underneath can never be set to a known value. The bench writes a pattern there and reads it back, and the read must not return that pattern. The aliasing of the character RAM is also hard to observe from outside. The bench writes through one slot with the outer bit clear and reads through another slot with the outer bit set. Both map to the same byte only if the +256 is folded away by the 8-bank modulo. The bench also sweeps all 256 override values across all four slots and derives each expected address arithmetically.

// File: rtl/cobx_pkg.sv
`timescale 1ns/1ps
package cobx_pkg;

    typedef enum logic [1:0] {
        PM_INNER  = 2'd0,
        PM_WIDE16 = 2'd1,
        PM_WIDE32 = 2'd2
    } prg_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_ROM   = 2'd2
    } rd_src_e;

    function automatic prg_mode_e mode_of(input logic [7:0] ovr);
        if (!ovr[7]) return PM_INNER;
        if (ovr[5])  return PM_WIDE32;
        return PM_WIDE16;
    endfunction

endpackage

// File: rtl/cobx_ctrl_regs.sv
`timescale 1ns/1ps
module cobx_ctrl_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  prg_ovr,
    output logic        chr_hi,
    output logic        reg_we
);
    assign reg_we = cpu_wr && (cpu_addr[15:1] == 15'h3000);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_ovr <= 8'h00;
            chr_hi  <= 1'b0;
        end else if (reg_we) begin
            if (!cpu_addr[0]) prg_ovr <= cpu_wdata;
            else              chr_hi  <= cpu_wdata[0];
        end
    end

    // R2
    ovr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h6000) |=> (prg_ovr == $past(cpu_wdata)));

    // R2
    chr_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h6001) |=> (chr_hi == $past(cpu_wdata[0])));

    // R11
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15:1] == 15'h3000) |=> ($stable(prg_ovr) && $stable(chr_hi)));

endmodule

// File: rtl/cobx_prg_xlat.sv
`timescale 1ns/1ps
module cobx_prg_xlat
    import cobx_pkg::*;
#(
    parameter int INNER_W   = 8,
    parameter int BANK_LOG2 = 5
) (
    input  logic [7:0]           ovr,
    input  logic [1:0]           slot,
    input  logic [4*INNER_W-1:0] inner_flat,
    output logic [BANK_LOG2-1:0] bank,
    output prg_mode_e            mode
);
    logic [INNER_W-1:0] inner_sel;
    logic [15:0]        cand;
    logic               ovr_unused;

    assign ovr_unused = ovr[6] ^ ovr[4];
    assign inner_sel  = inner_flat[slot*INNER_W +: INNER_W];
    assign mode       = mode_of(ovr);

    always_comb begin
        unique case (mode)
            PM_INNER:  cand = 16'(inner_sel);
            PM_WIDE16: cand = {11'b0, ovr[3:0], slot[0]};
            PM_WIDE32: cand = {11'b0, ovr[3:1], slot};
            default:   cand = 16'(inner_sel);
        endcase
    end

    assign bank = BANK_LOG2'(cand);

    generate
        if (BANK_LOG2 >= 2) begin : g_chk
            always_comb begin
                // R5
                if (mode == PM_WIDE16)
                    wide16_slot_chk: assert (bank[0] == slot[0] && bank[1] == ovr[0]);
                // R4
                if (mode == PM_WIDE32)
                    wide32_slot_chk: assert (bank[1:0] == slot);
            end
        end
    endgenerate

endmodule

// File: rtl/cobx_chr_xlat.sv
`timescale 1ns/1ps
module cobx_chr_xlat #(
    parameter int INNER_W   = 8,
    parameter int BANK_LOG2 = 9
) (
    input  logic [2:0]           slot,
    input  logic [8*INNER_W-1:0] inner_flat,
    input  logic                 hi,
    output logic [BANK_LOG2-1:0] bank
);
    logic [INNER_W-1:0] inner_sel;
    logic [16:0]        sum;

    assign inner_sel = inner_flat[slot*INNER_W +: INNER_W];
    assign sum       = 17'(inner_sel) + {8'b0, hi, 8'b0};
    assign bank      = BANK_LOG2'(sum);

endmodule

// File: rtl/cobx_sync_ram.sv
`timescale 1ns/1ps
module cobx_sync_ram #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/cart_outer_bank_xlat.sv
`timescale 1ns/1ps
module cart_outer_bank_xlat
    import cobx_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 5,
    parameter int CHR_BANKS_LOG2 = 9,
    parameter bit CHR_RAM        = 1'b0,
    parameter int INNER_W        = 8,
    localparam int CHR_LOG2_EFF  = CHR_RAM ? 3 : CHR_BANKS_LOG2,
    localparam int PRG_AW        = PRG_BANKS_LOG2 + 13,
    localparam int CHR_AW        = CHR_LOG2_EFF + 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic [7:0]           cpu_wdata,
    output logic [7:0]           cpu_rdata,
    output logic                 cpu_rvalid,
    input  logic [4*INNER_W-1:0] inner_prg_bank,
    input  logic [8*INNER_W-1:0] inner_chr_bank,
    output logic                 core_wr,
    output logic [15:0]          core_addr,
    output logic [7:0]           core_wdata,
    output logic                 prg_rom_rd,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    input  logic [7:0]           prg_rom_data,
    input  logic [13:0]          ppu_addr,
    input  logic                 ppu_rd,
    input  logic                 ppu_wr,
    input  logic [7:0]           ppu_wdata,
    output logic [7:0]           ppu_rdata,
    output logic                 ppu_rvalid,
    output logic                 chr_rom_rd,
    output logic [CHR_AW-1:0]    chr_rom_addr,
    input  logic [7:0]           chr_rom_data
);
    localparam int WRAM_AW = 13;

    logic [7:0]                prg_ovr;
    logic                      chr_hi;
    logic                      reg_we;
    logic [PRG_BANKS_LOG2-1:0] prg_bank;
    prg_mode_e                 prg_mode;
    logic [CHR_LOG2_EFF-1:0]   chr_bank;

    logic       in_rom, in_wram, ppu_in;
    logic       wram_we, wram_re;
    logic [7:0] wram_q;
    logic [7:0] chr_ram_q;
    rd_src_e    cpu_src_q, ppu_src_q, ppu_src_d;

    cobx_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .prg_ovr   (prg_ovr),
        .chr_hi    (chr_hi),
        .reg_we    (reg_we)
    );

    cobx_prg_xlat #(.INNER_W(INNER_W), .BANK_LOG2(PRG_BANKS_LOG2)) u_prg (
        .ovr        (prg_ovr),
        .slot       (cpu_addr[14:13]),
        .inner_flat (inner_prg_bank),
        .bank       (prg_bank),
        .mode       (prg_mode)
    );

    cobx_chr_xlat #(.INNER_W(INNER_W), .BANK_LOG2(CHR_LOG2_EFF)) u_chr (
        .slot       (ppu_addr[12:10]),
        .inner_flat (inner_chr_bank),
        .hi         (chr_hi),
        .bank       (chr_bank)
    );

    // CPU side decode
    assign in_rom       = cpu_addr[15];
    assign in_wram      = (cpu_addr[15:13] == 3'b011);
    assign prg_rom_rd   = cpu_rd && in_rom;
    assign prg_rom_addr = {prg_bank, cpu_addr[12:0]};
    assign wram_re      = cpu_rd && in_wram;
    assign wram_we      = cpu_wr && in_wram && (cpu_addr[12:1] != 12'd0);
    assign core_wr      = cpu_wr && in_rom;
    assign core_addr    = cpu_addr;
    assign core_wdata   = cpu_wdata;

    cobx_sync_ram #(.AW(WRAM_AW), .DW(8)) u_wram (
        .clk   (clk),
        .en    (wram_re || wram_we),
        .we    (wram_we),
        .addr  (cpu_addr[WRAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (wram_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)              cpu_src_q <= SRC_NONE;
        else if (cpu_rd && in_rom)  cpu_src_q <= SRC_ROM;
        else if (cpu_rd && in_wram) cpu_src_q <= SRC_LOCAL;
        else                     cpu_src_q <= SRC_NONE;
    end

    always_comb begin
        unique case (cpu_src_q)
            SRC_ROM:   begin cpu_rdata = prg_rom_data; cpu_rvalid = 1'b1; end
            SRC_LOCAL: begin cpu_rdata = wram_q;       cpu_rvalid = 1'b1; end
            default:   begin cpu_rdata = 8'h00;        cpu_rvalid = 1'b0; end
        endcase
    end

    // PPU side decode
    assign ppu_in       = !ppu_addr[13];
    assign chr_rom_addr = {chr_bank, ppu_addr[9:0]};

    generate
        if (CHR_RAM) begin : g_chr_ram
            logic rom_unused;
            assign rom_unused = ^chr_rom_data;
            assign chr_rom_rd = 1'b0;
            assign ppu_src_d  = (ppu_rd && ppu_in) ? SRC_LOCAL : SRC_NONE;
            cobx_sync_ram #(.AW(CHR_AW), .DW(8)) u_chr_ram (
                .clk   (clk),
                .en    ((ppu_rd || ppu_wr) && ppu_in),
                .we    (ppu_wr && ppu_in),
                .addr  (chr_rom_addr),
                .wdata (ppu_wdata),
                .rdata (chr_ram_q)
            );
        end else begin : g_chr_rom
            logic wdata_unused;
            assign wdata_unused = ^ppu_wdata ^ ppu_wr;
            assign chr_rom_rd   = ppu_rd && ppu_in;
            assign ppu_src_d    = (ppu_rd && ppu_in) ? SRC_ROM : SRC_NONE;
            assign chr_ram_q    = 8'h00;

            // R9
            rom_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ppu_wr && !ppu_rd) |-> !chr_rom_rd);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ppu_src_q <= SRC_NONE;
        else        ppu_src_q <= ppu_src_d;
    end

    always_comb begin
        unique case (ppu_src_q)
            SRC_ROM:   begin ppu_rdata = chr_rom_data; ppu_rvalid = 1'b1; end
            SRC_LOCAL: begin ppu_rdata = chr_ram_q;    ppu_rvalid = 1'b1; end
            default:   begin ppu_rdata = 8'h00;        ppu_rvalid = 1'b0; end
        endcase
    end

    // R11
    dest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_wr, wram_we, reg_we}));

    // R12
    cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_addr[15] && cpu_addr[14:13] != 2'b11) |=> !cpu_rvalid);

    // R12
    ppu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_rd && ppu_addr[13]) |=> !ppu_rvalid);

    // R1
    rom_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15]) |-> (prg_rom_rd && !wram_re));

    // R3
    inner_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_mode == PM_INNER) |-> !prg_ovr[7]);

endmodule

// File: tb/cart_outer_bank_xlat_tb.sv
`timescale 1ns/1ps
module cart_outer_bank_xlat_tb;
    localparam int PL = 5;
    localparam int CL = 9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata;
    logic [31:0] inner_prg;
    logic [63:0] inner_chr;
    logic [13:0] ppu_addr;
    logic        ppu_rd, ppu_wr;
    logic [7:0]  ppu_wdata;
    logic [7:0]  prg_rom_data, chr_rom_data;

    logic [7:0]       cpu_rdata, ppu_rdata, r_cpu_rdata, r_ppu_rdata;
    logic             cpu_rvalid, ppu_rvalid, r_cpu_rvalid, r_ppu_rvalid;
    logic             core_wr, r_core_wr;
    logic [15:0]      core_addr, r_core_addr;
    logic [7:0]       core_wdata, r_core_wdata;
    logic             prg_rom_rd, r_prg_rom_rd;
    logic [PL+12:0]   prg_rom_addr, r_prg_rom_addr;
    logic             chr_rom_rd, r_chr_rom_rd;
    logic [CL+9:0]    chr_rom_addr;
    logic [12:0]      r_chr_addr;

    logic [PL+12:0] prg_q;
    logic [CL+9:0]  chr_q;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    cart_outer_bank_xlat #(.PRG_BANKS_LOG2(PL), .CHR_BANKS_LOG2(CL), .CHR_RAM(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .inner_prg_bank(inner_prg), .inner_chr_bank(inner_chr),
        .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
        .prg_rom_rd(prg_rom_rd), .prg_rom_addr(prg_rom_addr), .prg_rom_data(prg_rom_data),
        .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .ppu_wdata(ppu_wdata),
        .ppu_rdata(ppu_rdata), .ppu_rvalid(ppu_rvalid),
        .chr_rom_rd(chr_rom_rd), .chr_rom_addr(chr_rom_addr), .chr_rom_data(chr_rom_data)
    );

    cart_outer_bank_xlat #(.PRG_BANKS_LOG2(PL), .CHR_BANKS_LOG2(CL), .CHR_RAM(1'b1)) u_dut_ram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(r_cpu_rdata), .cpu_rvalid(r_cpu_rvalid),
        .inner_prg_bank(inner_prg), .inner_chr_bank(inner_chr),
        .core_wr(r_core_wr), .core_addr(r_core_addr), .core_wdata(r_core_wdata),
        .prg_rom_rd(r_prg_rom_rd), .prg_rom_addr(r_prg_rom_addr), .prg_rom_data(prg_rom_data),
        .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .ppu_wdata(ppu_wdata),
        .ppu_rdata(r_ppu_rdata), .ppu_rvalid(r_ppu_rvalid),
        .chr_rom_rd(r_chr_rom_rd), .chr_rom_addr(r_chr_addr), .chr_rom_data(8'h00)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // ROM models: synchronous read, one cycle latency
    always_ff @(posedge clk) begin
        if (prg_rom_rd) prg_q <= prg_rom_addr;
        if (chr_rom_rd) chr_q <= chr_rom_addr;
    end
    assign prg_rom_data = pat(24'(prg_q));
    assign chr_rom_data = pat(24'(chr_q));

    function automatic logic [PL+12:0] exp_prg(input logic [7:0] v, input logic [15:0] a,
                                               input logic [7:0] inner);
        int s;
        int b;
        s = int'(a[14:13]);
        if (!v[7])     b = int'(inner);
        else if (v[5]) b = int'(v[3:1]) * 4 + s;
        else           b = int'(v[3:0]) * 2 + (s % 2);
        b = b % (1 << PL);
        return {5'(b), a[12:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ppu_read(input logic [13:0] a);
        @(negedge clk);
        ppu_addr = a; ppu_rd = 1'b1;
        @(negedge clk);
        ppu_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [PL+12:0] ea;
        rst_n = 1'b0; cpu_addr = 16'h0000; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = 8'h00;
        ppu_addr = 14'h0000; ppu_rd = 1'b0; ppu_wr = 1'b0; ppu_wdata = 8'h00;
        inner_prg = {8'h55, 8'h3A, 8'h07, 8'h1F};
        inner_chr = 64'h0102_0304_0506_0708;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state, pure inner banking
        #1;
        check(cpu_rvalid == 1'b0, "R10 cpu_rvalid", 32'(cpu_rvalid), 0);
        check(ppu_rvalid == 1'b0, "R10 ppu_rvalid", 32'(ppu_rvalid), 0);
        cpu_addr = 16'hC123; ppu_addr = 14'h0C40;
        #1;
        check(prg_rom_addr == {5'h1A, 13'h0123}, "R10 prg", 32'(prg_rom_addr), {5'h1A, 13'h0123});
        check(chr_rom_addr == {9'h005, 10'h040}, "R10 chr", 32'(chr_rom_addr), {9'h005, 10'h040});

        // R3 R4 R5 R6: every override value over every slot
        for (int v = 0; v < 256; v++) begin
            cpu_write(16'h6000, 8'(v));
            for (int s = 0; s < 4; s++) begin
                logic [15:0] a;
                logic [7:0]  inn;
                string       tag;
                inn = 8'(v * 7 + s * 53);
                inner_prg[s*8 +: 8] = inn;
                a = {1'b1, 2'(s), 13'(13'h0ABC ^ 13'(v))};
                cpu_addr = a;
                #1;
                if (!v[7]) tag = (inn >= 8'd32) ? "R6 inner" : "R3 inner";
                else if (v[5]) tag = "R4 wide32";
                else tag = "R5 wide16";
                ea = exp_prg(8'(v), a, inn);
                check(prg_rom_addr == ea, tag, 32'(prg_rom_addr), 32'(ea));
            end
        end

        // R1 R13: data path through the ROM, valid one cycle later
        cpu_write(16'h6000, 8'hFF);
        cpu_read(16'hA5A5);
        ea = exp_prg(8'hFF, 16'hA5A5, 8'h00);
        check(cpu_rvalid == 1'b1, "R13 rvalid", 32'(cpu_rvalid), 1);
        check(cpu_rdata == pat(24'(ea)), "R1 data wide32", 32'(cpu_rdata), 32'(pat(24'(ea))));
        cpu_write(16'h6000, 8'h8B);
        cpu_read(16'hE010);
        ea = exp_prg(8'h8B, 16'hE010, 8'h00);
        check(cpu_rdata == pat(24'(ea)), "R1 data wide16", 32'(cpu_rdata), 32'(pat(24'(ea))));
        @(negedge clk);
        check(cpu_rvalid == 1'b0, "R13 rvalid drop", 32'(cpu_rvalid), 0);

        // R2: only bit 0 kept in the outer character register
        cpu_write(16'h6000, 8'h00);
        for (int h = 0; h < 3; h++) begin
            logic [7:0] d;
            int         hi;
            d  = (h == 0) ? 8'hFE : ((h == 1) ? 8'h01 : 8'hFF);
            hi = int'(d[0]);
            cpu_write(16'h6001, d);
            for (int s = 0; s < 8; s++) begin
                logic [7:0] inn;
                int         eb;
                inn = 8'(s * 37 + h * 91);
                inner_chr[s*8 +: 8] = inn;
                ppu_addr = {1'b0, 3'(s), 10'(10'h155 ^ 10'(s))};
                #1;
                eb = (int'(inn) + 256 * hi) % 512;
                check(chr_rom_addr == {9'(eb), ppu_addr[9:0]}, "R7 R2 chr",
                      32'(chr_rom_addr), 32'({9'(eb), ppu_addr[9:0]}));
                eb = (int'(inn) + 256 * hi) % 8;
                check(r_chr_addr == {3'(eb), ppu_addr[9:0]}, "R6 chr ram",
                      32'(r_chr_addr), 32'({3'(eb), ppu_addr[9:0]}));
            end
        end

        // R7: character ROM data (outer bit is 1 here)
        inner_chr[7*8 +: 8] = 8'h9E;
        ppu_read(14'h1C22);
        check(ppu_rvalid == 1'b1, "R13 ppu rvalid", 32'(ppu_rvalid), 1);
        check(ppu_rdata == pat(24'({9'h19E, 10'h022})), "R7 chr data",
              32'(ppu_rdata), 32'(pat(24'({9'h19E, 10'h022}))));

        // R8: work RAM
        cpu_write(16'h6002, 8'h11);
        cpu_write(16'h7FFF, 8'h22);
        cpu_write(16'h6100, 8'h33);
        cpu_read(16'h6002);
        check(cpu_rvalid && cpu_rdata == 8'h11, "R8 ram 6002", 32'(cpu_rdata), 32'h11);
        cpu_read(16'h7FFF);
        check(cpu_rvalid && cpu_rdata == 8'h22, "R8 ram 7fff", 32'(cpu_rdata), 32'h22);
        cpu_read(16'h6100);
        check(cpu_rdata == 8'h33, "R8 ram 6100", 32'(cpu_rdata), 32'h33);
        cpu_write(16'h6000, 8'h5A);
        cpu_read(16'h6000);
        check(cpu_rvalid == 1'b1, "R8 read 6000 valid", 32'(cpu_rvalid), 1);
        check(cpu_rdata !== 8'h5A, "R8 no store 6000", 32'(cpu_rdata), 32'h5A);
        cpu_write(16'h6001, 8'hC3);
        cpu_read(16'h6001);
        check(cpu_rdata !== 8'hC3, "R8 no store 6001", 32'(cpu_rdata), 32'hC3);
        cpu_write(16'h6000, 8'h00);
        cpu_write(16'h6001, 8'h00);

        // R11: forwarding to the inner core, no local effect
        @(negedge clk);
        cpu_addr = 16'hE002; cpu_wdata = 8'h9C; cpu_wr = 1'b1;
        #1;
        check(core_wr == 1'b1, "R11 core_wr", 32'(core_wr), 1);
        check(core_addr == 16'hE002 && core_wdata == 8'h9C, "R11 core bus",
              {core_addr, 8'h00, core_wdata}, {16'hE002, 8'h00, 8'h9C});
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h8000, 8'hA5);
        @(negedge clk);
        cpu_addr = 16'h6000; cpu_wdata = 8'h80; cpu_wr = 1'b1;
        #1;
        check(core_wr == 1'b0, "R11 no fwd 6000", 32'(core_wr), 0);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_write(16'h6000, 8'h00);
        inner_prg[1*8 +: 8] = 8'h0D;
        cpu_addr = 16'hA000;
        #1;
        check(prg_rom_addr == {5'h0D, 13'h0000}, "R11 regs kept",
              32'(prg_rom_addr), {5'h0D, 13'h0000});
        cpu_write(16'hE100, 8'h77);
        cpu_read(16'h6100);
        check(cpu_rdata == 8'h33, "R11 ram kept", 32'(cpu_rdata), 32'h33);

        // R12: undecoded reads
        cpu_read(16'h4020);
        check(cpu_rvalid == 1'b0, "R12 cpu low", 32'(cpu_rvalid), 0);
        @(negedge clk);
        ppu_addr = 14'h2400; ppu_rd = 1'b1;
        #1;
        check(chr_rom_rd == 1'b0, "R12 no chr rd", 32'(chr_rom_rd), 0);
        @(negedge clk);
        ppu_rd = 1'b0;
        check(ppu_rvalid == 1'b0 && r_ppu_rvalid == 1'b0, "R12 ppu low",
              32'({ppu_rvalid, r_ppu_rvalid}), 0);

        // R9: character RAM stores, character ROM ignores writes
        inner_chr[0*8 +: 8] = 8'h02;
        inner_chr[5*8 +: 8] = 8'h02;
        @(negedge clk);
        ppu_addr = 14'h0010; ppu_wdata = 8'h6B; ppu_wr = 1'b1;
        #1;
        check(chr_rom_rd == 1'b0, "R9 rom write no access", 32'(chr_rom_rd), 0);
        @(negedge clk);
        ppu_wr = 1'b0;
        check(ppu_rvalid == 1'b0, "R9 rom write no data", 32'(ppu_rvalid), 0);
        cpu_write(16'h6001, 8'h01);
        ppu_read(14'h1410);
        check(r_ppu_rvalid && r_ppu_rdata == 8'h6B, "R9 ram readback alias",
              32'(r_ppu_rdata), 32'h6B);
        check(ppu_rdata == pat(24'({9'h102, 10'h010})), "R9 rom unchanged",
              32'(ppu_rdata), 32'(pat(24'({9'h102, 10'h010}))));

        done = 1'b1;
        finish_run();
    end

endmodule